// File: doc/BRIEF.md
# Buffer Occupancy Flow Controller

This block sits between a streaming data source and a large intermediate buffer. It keeps the source from overrunning the buffer and still leaves the buffer with enough data to serve the reader. It keeps its own count of how many words the buffer holds. The count goes up on every word the block writes into the buffer and down on every word the reader drains.

While the count is low, the block asks the source for data. Once the count reaches a high threshold, the block withdraws its request at the next packet boundary. It keeps the request withdrawn until the reader has emptied the buffer completely, and only then asks again. This wide hysteresis stops the request from toggling rapidly when the producer and consumer rates differ.

Words that are already on their way when the request falls are still written, up to a slack margin above the threshold. A word that arrives while the buffer is full is dropped and raises a sticky error. The incoming stream is cut into fixed-length packets: the block marks the final word of each packet and counts the packets it has completed.

Top module: `buf_flow_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `buf_level` is 0, `src_req` is 1, `ovf_err` is 0 and `pkt_count` is 0.
- R2: `buf_level` rises by one on each clock edge where a word is written and falls by one on each edge where `buf_rd` is 1 and the level is nonzero. A write and a read in the same cycle leave the level unchanged. A read at level 0 is ignored.
- R3: When `src_valid` is 1 and `buf_level` is below DEPTH (THRESH+SLACK), `buf_wr_en` is 1 in the same cycle and `buf_wr_data` equals `src_data`. At level DEPTH, `buf_wr_en` stays 0.
- R4: If, at a clock edge, `src_req` is 1, `buf_level` is at least THRESH and no packet is partly written, then `src_req` is 0 after that edge.
- R5: While a packet is partly written (the word position is nonzero), `src_req` does not fall, even at or above THRESH.
- R6: Once `src_req` is 0, it stays 0 until an edge at which `buf_level` is 0, and it is 1 after that edge.
- R7: Accepted words are numbered 0 to PKT_LEN-1 within a packet. The count continues across pauses. `buf_wr_last` is 1 exactly on word PKT_LEN-1, and words reach the buffer in arrival order.
- R8: `pkt_count` rises by one, wrapping at 2^CW, on the edge after each written word that has `buf_wr_last` set.
- R9: `ovf_err` becomes 1 on the edge after a cycle in which `src_valid` is 1 while `buf_level` equals DEPTH. It then stays 1 until reset, and the dropped word does not change `buf_level`.
- R10: Words arriving while `src_req` is 0 are still written, provided the level is below DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | output | 1 | Transfer request to the source |
| src_valid | input | 1 | Source word present this cycle |
| src_data | input | DW | Source word |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_data | output | DW | Word written to the buffer |
| buf_wr_last | output | 1 | Written word closes a packet |
| buf_rd | input | 1 | Reader drained one word this cycle |
| buf_level | output | $clog2(DEPTH+1) | Buffer occupancy in words |
| ovf_err | output | 1 | Sticky drop-on-full error |
| pkt_count | output | CW | Completed packets, wrapping |

## Verification
The write strobe, write data and last flag are combinational. They are due in the same cycle the source word is presented, so the bench checks them shortly after it drives the inputs and before the next edge. Level, request, error flag and packet count are registered and change one edge after their cause. The bench's reference model advances its expected values at that edge and compares them at the following falling edge, just before new inputs go out. Written words go into a scoreboard queue when the driver expects them to be accepted, and a monitor pops and compares them in the cycle the strobe appears.

// File: rtl/buf_flow_pkg.sv
package buf_flow_pkg;
  typedef enum logic {
    GATE_RUN  = 1'b0,
    GATE_HOLD = 1'b1
  } gate_state_t;
endpackage

// File: rtl/fc_occupancy.sv
module fc_occupancy #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          rd_req,
  output logic [LW-1:0] level,
  output logic          full
);
  logic [LW-1:0] level_q, level_d;
  logic          dec;

  assign dec = rd_req & (level_q != '0);

  always_comb begin
    level_d = level_q;
    case ({inc, dec})
      2'b10:   level_d = level_q + 1'b1;
      2'b01:   level_d = level_q - 1'b1;
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  assign level = level_q;
  assign full  = (level_q == LW'(DEPTH));
endmodule

// File: rtl/fc_packetizer.sv
module fc_packetizer #(
  parameter int PKT_LEN = 4,
  parameter int PW      = 2,
  parameter int CW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  output logic [PW-1:0] pos,
  output logic          last,
  output logic [CW-1:0] pkt_count
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  generate
    if (PKT_LEN > 1) begin : g_multi
      logic [PW-1:0] pos_q, pos_d;
      always_comb begin
        pos_d = pos_q;
        if (acc) begin
          if (pos_q == PW'(PKT_LEN-1)) pos_d = '0;
          else                         pos_d = pos_q + 1'b1;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
      end
      assign pos  = pos_q;
      assign last = (pos_q == PW'(PKT_LEN-1));
    end else begin : g_single
      assign pos  = '0;
      assign last = 1'b1;
    end
  endgenerate

  assign cnt_en = acc & last;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pkt_count = cnt_q;
endmodule

// File: rtl/fc_req_gate.sv
module fc_req_gate
  import buf_flow_pkg::*;
#(
  parameter int THRESH = 12,
  parameter int LW     = 5,
  parameter int PW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] level,
  input  logic [PW-1:0] pos,
  output logic          src_req
);
  gate_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      GATE_RUN:  if (level >= LW'(THRESH) && pos == '0) st_d = GATE_HOLD;
      GATE_HOLD: if (level == '0)                        st_d = GATE_RUN;
      default:   st_d = GATE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GATE_RUN;
    else        st_q <= st_d;
  end

  assign src_req = (st_q == GATE_RUN);
endmodule

// File: rtl/buf_flow_ctrl.sv
module buf_flow_ctrl #(
  parameter int DW      = 16,
  parameter int THRESH  = 12,
  parameter int SLACK   = 4,
  parameter int PKT_LEN = 4,
  parameter int CW      = 8,
  localparam int DEPTH  = THRESH + SLACK,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          src_req,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          buf_wr_en,
  output logic [DW-1:0] buf_wr_data,
  output logic          buf_wr_last,
  input  logic          buf_rd,
  output logic [LW-1:0] buf_level,
  output logic          ovf_err,
  output logic [CW-1:0] pkt_count
);
  localparam int PW = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;

  logic          full;
  logic          accept;
  logic          pkt_last;
  logic [PW-1:0] pkt_pos;
  logic          ovf_q, ovf_d;

  assign accept = src_valid & ~full;

  fc_occupancy #(.DEPTH(DEPTH), .LW(LW)) u_occ (
    .clk(clk), .rst_n(rst_n), .inc(accept), .rd_req(buf_rd),
    .level(buf_level), .full(full)
  );

  fc_packetizer #(.PKT_LEN(PKT_LEN), .PW(PW), .CW(CW)) u_pkt (
    .clk(clk), .rst_n(rst_n), .acc(accept),
    .pos(pkt_pos), .last(pkt_last), .pkt_count(pkt_count)
  );

  fc_req_gate #(.THRESH(THRESH), .LW(LW), .PW(PW)) u_gate (
    .clk(clk), .rst_n(rst_n), .level(buf_level), .pos(pkt_pos),
    .src_req(src_req)
  );

  always_comb begin
    ovf_d = ovf_q;
    if (src_valid && full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign ovf_err     = ovf_q;
  assign buf_wr_en   = accept;
  assign buf_wr_data = src_data;
  assign buf_wr_last = pkt_last;
endmodule

// File: rtl/buf_flow_ctrl_chk.sv
module buf_flow_ctrl_chk #(
  parameter int THRESH = 12,
  parameter int DEPTH  = 16,
  parameter int LW     = 5,
  parameter int PW     = 2,
  parameter int CW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          src_req,
  input logic          src_valid,
  input logic          buf_wr_en,
  input logic          buf_wr_last,
  input logic          buf_rd,
  input logic [LW-1:0] buf_level,
  input logic          ovf_err,
  input logic [CW-1:0] pkt_count,
  input logic [PW-1:0] pkt_pos
);
  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_level <= LW'(DEPTH));

  assert_level_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr_en && !buf_rd) |=> buf_level == $past(buf_level) + 1'b1);

  assert_no_write_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_level == LW'(DEPTH)) |-> !buf_wr_en);

  assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && buf_level >= LW'(THRESH) && pkt_pos == '0) |=> !src_req);

  assert_req_mid_packet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && pkt_pos != '0) |=> src_req);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_req && buf_level != '0) |=> !src_req);

  assert_pkt_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr_en && buf_wr_last) |=> pkt_count == $past(pkt_count) + 1'b1);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && buf_level == LW'(DEPTH)) |=> ovf_err);
endmodule

bind buf_flow_ctrl buf_flow_ctrl_chk #(
  .THRESH(THRESH), .DEPTH(DEPTH), .LW(LW), .PW(PW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_valid(src_valid),
  .buf_wr_en(buf_wr_en), .buf_wr_last(buf_wr_last), .buf_rd(buf_rd),
  .buf_level(buf_level), .ovf_err(ovf_err), .pkt_count(pkt_count),
  .pkt_pos(pkt_pos)
);

// File: tb/sim_buf_flow_ctrl.sv
`timescale 1ns/100ps
module sim_buf_flow_ctrl;
  localparam int DW = 16, THRESH = 12, SLACK = 4, PKT_LEN = 4, CW = 8;
  localparam int DEPTH = THRESH + SLACK;
  localparam int LW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          src_req, src_valid, buf_wr_en, buf_wr_last, buf_rd, ovf_err;
  logic [DW-1:0] src_data, buf_wr_data;
  logic [LW-1:0] buf_level;
  logic [CW-1:0] pkt_count;

  always #2 clk = ~clk;

  buf_flow_ctrl #(.DW(DW), .THRESH(THRESH), .SLACK(SLACK), .PKT_LEN(PKT_LEN), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_valid(src_valid),
    .src_data(src_data), .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data),
    .buf_wr_last(buf_wr_last), .buf_rd(buf_rd), .buf_level(buf_level),
    .ovf_err(ovf_err), .pkt_count(pkt_count)
  );

  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [DW:0] sb[$];
  int          m_level = 0, m_pos = 0, m_pkt = 0;
  bit          m_req = 1'b1, m_ovf = 1'b0;
  string       req_tag = "R1 request";
  int          next_data = 16'h100;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_regs();
    chk("R2 level", int'(buf_level), m_level);
    chk(req_tag, int'(src_req), int'(m_req));
    chk("R8 packet count", int'(pkt_count), m_pkt);
    chk("R9 overflow flag", int'(ovf_err), int'(m_ovf));
  endtask

  task automatic step(input bit v, input bit rd);
    bit acc;
    @(negedge clk);
    compare_regs();
    src_valid = v;
    src_data  = DW'(next_data);
    buf_rd    = rd;
    #1;
    acc = v && (m_level < DEPTH);
    chk((acc && !m_req) ? "R10 in-flight accept" : "R3 write enable", int'(buf_wr_en), int'(acc));
    if (acc) sb.push_back({(m_pos == PKT_LEN-1), DW'(next_data)});
    if (m_req && m_level >= THRESH && m_pos == 0) begin
      m_req = 1'b0; req_tag = "R4 request drop";
    end else if (!m_req && m_level == 0) begin
      m_req = 1'b1; req_tag = "R6 request resume";
    end else if (m_req && m_level >= THRESH) begin
      req_tag = "R5 request held mid-packet";
    end else begin
      req_tag = m_req ? "R4 request kept" : "R6 request held";
    end
    if (v && !acc) m_ovf = 1'b1;
    m_level = m_level + (acc ? 1 : 0) - ((rd && m_level > 0) ? 1 : 0);
    if (acc) begin
      if (m_pos == PKT_LEN-1) begin
        m_pos = 0;
        m_pkt = (m_pkt + 1) % (1 << CW);
      end else begin
        m_pos = m_pos + 1;
      end
    end
    next_data++;
  endtask

  // Monitor: pops expected words as the design writes them (R7)
  always @(negedge clk) begin
    #1.5;
    if (rst_n === 1'b1 && buf_wr_en === 1'b1) begin
      if (sb.size() == 0) begin
        chk("R7 unexpected write", 1, 0);
      end else begin
        logic [DW:0] e;
        e = sb.pop_front();
        chk("R7 write data", int'(buf_wr_data), int'(e[DW-1:0]));
        chk("R7 last flag", int'(buf_wr_last), int'(e[DW]));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_valid = 1'b0; src_data = '0; buf_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset level", int'(buf_level), 0);
    chk("R1 reset request", int'(src_req), 1);
    rst_n = 1'b1;
    #1;
    chk("R1 reset overflow", int'(ovf_err), 0);
    chk("R1 reset packets", int'(pkt_count), 0);
    // Offset the packet position, then drain with extra reads at empty (R2)
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
    // Stream past the threshold mid-packet (R5), drop (R4), slack (R10), overflow (R9)
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    // Writes together with reads (R2), then a full drain and resume (R6)
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
    // Mixed traffic
    for (int i = 0; i < 40; i++) step((i % 3) != 0, (i % 2) == 1);
    for (int i = 0; i < 30; i++) step(1'b1, (i % 4) == 0);
    for (int i = 0; i < 24; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    @(negedge clk);
    compare_regs();
    chk("R7 scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule